// File: doc/BRIEF.md
# Receive Word Nibble Serializer

This block sits between a receive sample source and a narrow parallel output bus. Each 10-bit receive word is sent over a 6-bit bus in two halves on two consecutive clock cycles. A sync line tags each half: it is low for the first half of a word and high for the second. The receiving side uses the sync level to pair the halves and rebuild the word.

Words enter through a valid/ready handshake. The block accepts a new word only in the cycle in which the second half of the current word is on the bus, so words follow one another with no gap and the sync line toggles every cycle. If the source has nothing to offer at that point, the block sends the last word again. A configuration input picks which half goes first. A second configuration input sets the polarity of a forwarded port clock, so that the receiver can capture on either edge in the middle of each bus cycle.

Top module: `rxNibbleSerializer`

## Requirements
- R1: While reset is active, and after reset until the first word is accepted, `portSync` is low, `portBus` is zero and `inReady` is high.
- R2: A word is accepted on a rising edge where `inValid` and `inReady` are both high. Its first half is on the bus with `portSync` low in the next cycle, and its second half follows in the cycle after that with `portSync` high. From the first accepted word onward, `portSync` toggles every cycle.
- R3: With `cfgLsbFirst` low, the half sent with sync low is word bits 9:4 on `portBus[5:0]`. The half sent with sync high is word bits 3:0 on `portBus[5:2]`, with `portBus[1:0]` driven to zero.
- R4: With `cfgLsbFirst` high, the half sent with sync low is word bits 3:0 on `portBus[5:2]` with `portBus[1:0]` zero, and the half sent with sync high is word bits 9:4 on `portBus[5:0]`.
- R5: The order is taken from `cfgLsbFirst` at the edge that starts a sync-low cycle. It stays fixed for the sync-high half of the same word, even if `cfgLsbFirst` changes in between.
- R6: Once a word has been accepted, `inReady` is high exactly in the cycles where `portSync` is high.
- R7: If no word is offered while `inReady` is high after the first accept, the last word is sent again, both halves, with the order taken afresh as in R5.
- R8: While `inReady` is low, `inValid` and `inData` have no effect on the bus.
- R9: With `cfgClkInvert` low, `portClk` is the inverse of `clk`, so it rises in the middle of each bus cycle. With `cfgClkInvert` high, `portClk` follows `clk`, so it falls at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus and sync change on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLsbFirst | input | 1 | 1 sends the low half of each word first |
| cfgClkInvert | input | 1 | 1 puts the capture edge of `portClk` on its falling edge |
| inData | input | 10 | Receive word offered by the source |
| inValid | input | 1 | `inData` holds a word |
| inReady | output | 1 | The block takes the offered word at this edge |
| portSync | output | 1 | Low on the first half of a word, high on the second |
| portBus | output | 6 | Word half, justified toward bit 5 |
| portClk | output | 1 | Forwarded capture clock |

## Verification
The bus and sync are registered. A word taken at rising edge k is visible after edge k with sync low, and its second half is visible after edge k+1. `inReady` depends only on registered state, so it settles just after each edge. `portClk` follows `clk` combinationally. The bench advances a behavioural model at each rising edge from the inputs it drove one nanosecond after the previous edge. It compares bus, sync and ready on the falling edge, half a period after the edge that set them, and it checks `portClk` both halfway through the high phase of `clk` and on the falling edge.

// File: rtl/rxSerPkg.sv
package rxSerPkg;

  // Strobes from control to datapath for the next bus cycle.
  typedef struct packed {
    logic loadWord;   // capture inData into the word holder
    logic emitFirst;  // drive the first half next cycle, sync low
    logic emitSecond; // drive the second half next cycle, sync high
  } serStrobe_t;

endpackage

// File: rtl/rxSerNibbles.sv
// Splits a word into its high part (full bus width) and its low part,
// which is justified toward the top bus bit with zero padding below.
module rxSerNibbles #(
  parameter int WORD_W = 10,
  parameter int BUS_W  = 6
) (
  input  logic [WORD_W-1:0] word,
  output logic [BUS_W-1:0]  hiPart,
  output logic [BUS_W-1:0]  loPart
);
  localparam int LO_W  = WORD_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  assign hiPart = word[WORD_W-1:LO_W];

  generate
    if (PAD_W > 0) begin : gPad
      assign loPart = {word[LO_W-1:0], {PAD_W{1'b0}}};
    end else begin : gNoPad
      assign loPart = word[LO_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rxSerCtrl.sv
// Phase control: tracks whether a word is held and which half is on the bus.
module rxSerCtrl
  import rxSerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output serStrobe_t strb
);
  logic loaded;     // a word has been accepted since reset
  logic phaseHigh;  // the second half is on the bus now

  assign inReady = !loaded || phaseHigh;

  always_comb begin
    strb = '0;
    if (!loaded) begin
      strb.loadWord  = inValid;
      strb.emitFirst = inValid;
    end else if (!phaseHigh) begin
      strb.emitSecond = 1'b1;
    end else begin
      strb.loadWord  = inValid;
      strb.emitFirst = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loaded    <= 1'b0;
      phaseHigh <= 1'b0;
    end else if (strb.emitFirst) begin
      loaded    <= 1'b1;
      phaseHigh <= 1'b0;
    end else if (strb.emitSecond) begin
      phaseHigh <= 1'b1;
    end
  end
endmodule

// File: rtl/rxSerPath.sv
// Datapath: holds the word, latches the order, registers bus and sync.
module rxSerPath
  import rxSerPkg::*;
#(
  parameter int WORD_W = 10,
  parameter int BUS_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strb,
  input  logic              cfgLsbFirst,
  input  logic [WORD_W-1:0] inData,
  output logic [BUS_W-1:0]  portBus,
  output logic              portSync
);
  logic [WORD_W-1:0] wordReg;
  logic              orderReg;  // order in force for the word on the bus
  logic [WORD_W-1:0] srcWord;
  logic [BUS_W-1:0]  srcHi, srcLo, heldHi, heldLo;
  logic [BUS_W-1:0]  firstNib, secondNib;

  // A newly accepted word bypasses the holder into the first half.
  assign srcWord = strb.loadWord ? inData : wordReg;

  rxSerNibbles #(.WORD_W(WORD_W), .BUS_W(BUS_W)) uSrcSplit (
    .word(srcWord), .hiPart(srcHi), .loPart(srcLo)
  );
  rxSerNibbles #(.WORD_W(WORD_W), .BUS_W(BUS_W)) uHeldSplit (
    .word(wordReg), .hiPart(heldHi), .loPart(heldLo)
  );

  assign firstNib  = cfgLsbFirst ? srcLo : srcHi;
  assign secondNib = orderReg ? heldHi : heldLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg  <= '0;
      orderReg <= 1'b0;
      portBus  <= '0;
      portSync <= 1'b0;
    end else begin
      if (strb.loadWord) wordReg <= inData;
      if (strb.emitFirst) begin
        orderReg <= cfgLsbFirst;
        portBus  <= firstNib;
        portSync <= 1'b0;
      end else if (strb.emitSecond) begin
        portBus  <= secondNib;
        portSync <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxNibbleSerializer.sv
module rxNibbleSerializer
  import rxSerPkg::*;
#(
  parameter int WORD_W = 10,
  parameter int BUS_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLsbFirst,
  input  logic              cfgClkInvert,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              portSync,
  output logic [BUS_W-1:0]  portBus,
  output logic              portClk
);
  serStrobe_t strb;

  rxSerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .strb(strb)
  );

  rxSerPath #(.WORD_W(WORD_W), .BUS_W(BUS_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgLsbFirst(cfgLsbFirst),
    .inData(inData), .portBus(portBus), .portSync(portSync)
  );

  // Default: the rising edge falls mid-cycle; inverted: the falling edge does.
  assign portClk = cfgClkInvert ? clk : ~clk;
endmodule

// File: rtl/rxSerCheck.sv
module rxSerCheck #(
  parameter int WORD_W = 10,
  parameter int BUS_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLsbFirst,
  input logic [WORD_W-1:0] inData,
  input logic              inValid,
  input logic              inReady,
  input logic              portSync,
  input logic [BUS_W-1:0]  portBus
);
  localparam int LO_W  = WORD_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;
  localparam logic [BUS_W-1:0] PAD_MASK = BUS_W'((1 << PAD_W) - 1);

  AST_SYNC_HIGH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    portSync |=> !portSync); // R2

  AST_FIRST_THEN_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (!portSync && !inReady) |=> portSync); // R2

  AST_ACCEPT_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !portSync); // R2

  AST_READY_WITH_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    portSync |-> inReady); // R6

  AST_NO_READY_ON_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(portSync) |-> !inReady); // R6

  AST_MS_FIRST_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !cfgLsbFirst) |=>
      portBus == $past(inData[WORD_W-1:LO_W])); // R3

  AST_LS_FIRST_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && cfgLsbFirst) |=>
      (portBus[BUS_W-1:PAD_W] == $past(inData[LO_W-1:0])) &&
      ((portBus & PAD_MASK) == '0)); // R4
endmodule

bind rxNibbleSerializer rxSerCheck #(.WORD_W(WORD_W), .BUS_W(BUS_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgLsbFirst(cfgLsbFirst), .inData(inData),
  .inValid(inValid), .inReady(inReady), .portSync(portSync), .portBus(portBus)
);

// File: tb/rxNibbleSerializer_test.sv
`timescale 1ns/1ps
module rxNibbleSerializer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLsbFirst = 1'b0;
  logic       cfgClkInvert = 1'b0;
  logic [9:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady, portSync, portClk;
  logic [5:0] portBus;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string curTag = "R1";

  // Behavioural reference state
  int  mLoaded = 0, mHigh = 0, mLsb = 0;
  int  mWord = 0;
  int  mBus = 0, mSync = 0;

  always #2 clk = ~clk; // 250 MHz

  rxNibbleSerializer uut (
    .clk(clk), .rstN(rstN), .cfgLsbFirst(cfgLsbFirst), .cfgClkInvert(cfgClkInvert),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .portSync(portSync), .portBus(portBus), .portClk(portClk)
  );

  function automatic int hiOf(int w); return (w >> 4) & 63; endfunction
  function automatic int loOf(int w); return (w & 15) << 2; endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Model advances on each rising edge from inputs driven 1 ns after the previous one.
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mLoaded = 0; mHigh = 0; mLsb = 0; mWord = 0; mBus = 0; mSync = 0;
    end else if (mLoaded == 0 || mHigh == 1) begin
      if (inValid) mWord = int'(inData);
      if (inValid || mLoaded == 1) begin
        mLsb = int'(cfgLsbFirst);
        mBus = mLsb ? loOf(mWord) : hiOf(mWord);
        mSync = 0; mHigh = 0; mLoaded = 1;
      end
    end else begin
      mBus = mLsb ? hiOf(mWord) : loOf(mWord);
      mSync = 1; mHigh = 1;
    end
  end

  // Compare half a period after the edge that set the outputs.
  always @(negedge clk) begin
    if (rstN) begin
      check(curTag, int'(portBus), mBus);
      check("R2 sync", int'(portSync), mSync);
      check("R6 ready", int'(inReady), (mLoaded == 0 || mHigh == 1) ? 1 : 0);
      check("R9 portClk low phase", int'(portClk), cfgClkInvert ? 0 : 1);
    end
  end

  task automatic stepIn(bit v, int d);
    @(posedge clk); #1;
    inValid = v;
    inData  = 10'(d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs during reset
    check("R1 reset bus", int'(portBus), 0);
    check("R1 reset sync", int'(portSync), 0);
    check("R1 reset ready", int'(inReady), 1);
    rstN = 1'b1;
    curTag = "R1 idle bus";
    for (int i = 0; i < 5; i++) stepIn(0, 10'h3FF);

    // R3: default order, corner words, valid held high
    curTag = "R3 ms-first bus";
    stepIn(1, 10'h3FF); stepIn(1, 10'h000); stepIn(1, 10'h2AA);
    stepIn(1, 10'h155); stepIn(1, 10'h0F0);
    for (int i = 0; i < 40; i++) stepIn(1, int'($urandom_range(0, 1023)));

    // R8: data changing every cycle while ready is low is ignored (covered above);
    // here valid pulses only while ready is low.
    curTag = "R8 ignored-offer bus";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #0.5;
      inValid = !inReady;
      inData  = 10'($urandom_range(0, 1023));
    end
    stepIn(0, 0);

    // R7: sparse offers, held word repeats
    curTag = "R7 repeat bus";
    stepIn(1, 10'h1C3);
    for (int i = 0; i < 10; i++) stepIn(0, 10'h3FF);
    for (int i = 0; i < 30; i++) stepIn(($urandom_range(0, 3) == 0), int'($urandom_range(0, 1023)));

    // R4: low half first
    curTag = "R4 ls-first bus";
    cfgLsbFirst = 1'b1;
    stepIn(1, 10'h3FF); stepIn(1, 10'h001); stepIn(1, 10'h3F0);
    for (int i = 0; i < 30; i++) stepIn(1, int'($urandom_range(0, 1023)));

    // R5: order toggles every cycle, taken only at first-half edges
    curTag = "R5 order-latch bus";
    for (int i = 0; i < 40; i++) begin
      stepIn($urandom_range(0, 1) == 1, int'($urandom_range(0, 1023)));
      cfgLsbFirst = ~cfgLsbFirst;
    end

    // R9: clock polarity in both settings, checked also in the high phase
    curTag = "R9 bus";
    for (int k = 0; k < 2; k++) begin
      cfgClkInvert = k[0];
      for (int i = 0; i < 6; i++) begin
        stepIn(1, int'($urandom_range(0, 1023)));
        check("R9 portClk high phase", int'(portClk), cfgClkInvert ? 1 : 0);
      end
    end

    stepIn(0, 0);
    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule